// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block brings one power partition of a chip from off to running, in an order that is safe for the logic inside it. A single start pulse carries a partition index. The sequencer then goes through a fixed series of steps:

- It holds the partition's peripheral reset.
- It asks the partition controller to apply power.
- It turns the partition clock on and waits for the clock acknowledge.
- It waits a programmable settle window.
- It asks the controller to release the isolation clamps.
- It waits the same window again.
- It lets go of the reset.

The caller supplies the settle length as a cycle count worth about 10 µs at its own clock.

Some failures are detected after power has been requested. In that case the block undoes its own work, last step first: the clock goes off, then a power-off request goes out, and then the error is reported. A request that names a partition the block does not have is turned away at once and nothing is touched. A request for a partition that already reports power is refused as invalid.

States and transitions:

- IDLE goes to RST_ON on a valid start, or to FAIL on a bad index.
- RST_ON goes to FAIL if the partition is already powered, otherwise to PWR_REQ.
- PWR_REQ goes to CLK_ON.
- CLK_ON goes to SETTLE1 on the acknowledge, or to UNDO_CLK on timeout.
- SETTLE1 goes to CLAMP, CLAMP to SETTLE2, SETTLE2 to DONE, and DONE to IDLE.
- UNDO_CLK goes to UNDO_PWR, UNDO_PWR to FAIL, and FAIL to IDLE.

Top module: `pup_sequencer`

## Requirements
- R1: The steps come in this order:
  - the reset goes high, or is already high, before the one-cycle power-on request;
  - the clock enable rises the cycle after that request;
  - the clamp-release pulse comes only while the clock is enabled and the reset is held;
  - the reset falls in the same cycle as the done pulse.
- R2: With the acknowledge already high and a settle count N, the clamp-release pulse starts N+1 cycles after the clock enable rises, and done starts N+1 cycles after the clamp pulse. A count of 0 acts as 1.
- R3: If the selected partition's power-status bit is already 1 when the power step is reached, no power-on request is issued. The clock stays off, the reset stays held, and error comes with cause code 2.
- R4: If no acknowledge arrives within ACK_TIMEOUT cycles of the clock enable rising, the block unwinds. The clock enable stays high for exactly ACK_TIMEOUT cycles. A one-cycle power-off request follows in the next cycle, and error with cause 3 in the cycle after that.
- R5: A start with an index at or above NUM_PARTS gives error with cause 1 in the very next cycle. It issues no request and leaves the reset, clock enable and reported index unchanged.
- R6: Start pulses that arrive while busy are ignored, and the running sequence keeps its index and timing.
- R7: Done and error are one-cycle pulses. The 2-bit cause code holds its value until the next start, and an accepted valid start clears it to 0.
- R8: After reset the block is idle with reset held, the clock disabled, no request or result pulse, and cause 0.
- R9: The index output carries the requested partition during the power-on, clamp-release and power-off pulses.
- R10: On success the clock is left enabled and the reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| part_idx_i | input | IDX_W | Partition to bring up |
| settle_cycles_i | input | CNT_W | Length of each settle window in cycles |
| pwr_status_i | input | NUM_PARTS | Power-good status of each partition |
| clk_ack_i | input | 1 | Clock-enable acknowledge |
| periph_rst_o | output | 1 | Peripheral reset to the partition |
| clk_en_o | output | 1 | Partition clock enable |
| pwr_on_req_o | output | 1 | One-cycle power-on request |
| pwr_off_req_o | output | 1 | One-cycle power-off request (unwind) |
| clamp_rel_req_o | output | 1 | One-cycle clamp-release request |
| req_idx_o | output | IDX_W | Partition the requests refer to |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse |
| err_cause_o | output | 2 | 0 none, 1 bad index, 2 already powered, 3 clock timeout |

## Verification
The bench measures cycle distances between pulses for several settle counts, including 0. An off-by-one in the settle counter, or a counter that is not cleared between the two windows, therefore shows up as a shifted clamp or done pulse. The unwind path is driven with the acknowledge held low. A design that skipped the power-off, powered off before dropping the clock, or miscounted the timeout would show the wrong clock-high length or the wrong pulse order. A bad index is sent right after a successful bring-up, so a design that disturbed the reset or clock on rejection would flip them visibly. A second start is fired into a running sequence to catch a design that restarts or latches the new index.

// File: rtl/pup_pkg.sv
package pup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_ON,
        ST_PWR_REQ,
        ST_CLK_ON,
        ST_SETTLE1,
        ST_CLAMP,
        ST_SETTLE2,
        ST_DONE,
        ST_UNDO_CLK,
        ST_UNDO_PWR,
        ST_FAIL
    } pup_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE        = 2'd0,
        CAUSE_BAD_INDEX   = 2'd1,
        CAUSE_ALREADY_ON  = 2'd2,
        CAUSE_CLK_TIMEOUT = 2'd3
    } pup_cause_e;

endpackage

// File: rtl/pup_delay_cnt.sv
// Saturating up-counter: hit_o is high from the cycle in which the
// window of lim_i cycles has elapsed (a limit of 0 behaves as 1).
module pup_delay_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] lim_i,
    output logic         hit_o
);

    logic [W-1:0] cnt_q;

    assign hit_o = ({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, lim_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (!hit_o) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // Window counter never runs backwards while a window is open (R2).
    p_cnt_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/pup_index_chk.sv
// Range check and one-hot select of a partition index.
module pup_index_chk #(
    parameter int NUM_PARTS = 8,
    parameter int IDX_W     = 4
) (
    input  logic [IDX_W-1:0]     idx_i,
    output logic                 valid_o,
    output logic [NUM_PARTS-1:0] sel_o
);

    assign valid_o = {1'b0, idx_i} < (IDX_W+1)'(NUM_PARTS);

    for (genvar g = 0; g < NUM_PARTS; g++) begin : g_sel
        assign sel_o[g] = (idx_i == IDX_W'(g));
    end

    always_comb begin
        assert (!valid_o || $onehot(sel_o));
    end

endmodule

// File: rtl/pup_sequencer.sv
module pup_sequencer
    import pup_pkg::*;
#(
    parameter int NUM_PARTS   = 8,
    parameter int IDX_W       = 4,
    parameter int CNT_W       = 16,
    parameter int ACK_TIMEOUT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [IDX_W-1:0]     part_idx_i,
    input  logic [CNT_W-1:0]     settle_cycles_i,
    input  logic [NUM_PARTS-1:0] pwr_status_i,
    input  logic                 clk_ack_i,
    output logic                 periph_rst_o,
    output logic                 clk_en_o,
    output logic                 pwr_on_req_o,
    output logic                 pwr_off_req_o,
    output logic                 clamp_rel_req_o,
    output logic [IDX_W-1:0]     req_idx_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [1:0]           err_cause_o
);

    localparam int ACK_W = $clog2(ACK_TIMEOUT + 1);

    pup_state_e state_q, state_d;
    pup_cause_e cause_q;
    logic [IDX_W-1:0]     idx_q;
    logic [IDX_W-1:0]     chk_idx;
    logic [NUM_PARTS-1:0] sel;
    logic                 idx_ok;
    logic                 powered;
    logic                 periph_rst_q, clk_en_q;
    logic                 settle_hit, ack_hit;
    logic                 settle_clr, ack_clr;

    // In idle the incoming index is checked; afterwards the latched one.
    assign chk_idx = (state_q == ST_IDLE) ? part_idx_i : idx_q;

    pup_index_chk #(.NUM_PARTS(NUM_PARTS), .IDX_W(IDX_W)) u_idx (
        .idx_i   (chk_idx),
        .valid_o (idx_ok),
        .sel_o   (sel)
    );

    assign powered = |(pwr_status_i & sel);

    assign settle_clr = !((state_q == ST_SETTLE1) || (state_q == ST_SETTLE2));
    assign ack_clr    = (state_q != ST_CLK_ON);

    pup_delay_cnt #(.W(CNT_W)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (settle_clr),
        .lim_i (settle_cycles_i),
        .hit_o (settle_hit)
    );

    pup_delay_cnt #(.W(ACK_W)) u_ackwait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ack_clr),
        .lim_i (ACK_W'(ACK_TIMEOUT)),
        .hit_o (ack_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = idx_ok ? ST_RST_ON : ST_FAIL;
            ST_RST_ON:   state_d = powered ? ST_FAIL : ST_PWR_REQ;
            ST_PWR_REQ:  state_d = ST_CLK_ON;
            ST_CLK_ON: begin
                if (clk_ack_i)    state_d = ST_SETTLE1;
                else if (ack_hit) state_d = ST_UNDO_CLK;
            end
            ST_SETTLE1:  if (settle_hit) state_d = ST_CLAMP;
            ST_CLAMP:    state_d = ST_SETTLE2;
            ST_SETTLE2:  if (settle_hit) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            ST_UNDO_CLK: state_d = ST_UNDO_PWR;
            ST_UNDO_PWR: state_d = ST_FAIL;
            ST_FAIL:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers, updated on entry to the state that owns them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            periph_rst_q <= 1'b1;
            clk_en_q     <= 1'b0;
            cause_q      <= CAUSE_NONE;
            idx_q        <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                cause_q <= idx_ok ? CAUSE_NONE : CAUSE_BAD_INDEX;
                if (idx_ok) idx_q <= part_idx_i;
            end
            if (state_q == ST_RST_ON && powered)
                cause_q <= CAUSE_ALREADY_ON;
            if (state_q == ST_CLK_ON && !clk_ack_i && ack_hit)
                cause_q <= CAUSE_CLK_TIMEOUT;
            if (state_d == ST_RST_ON)   periph_rst_q <= 1'b1;
            if (state_d == ST_DONE)     periph_rst_q <= 1'b0;
            if (state_d == ST_CLK_ON)   clk_en_q     <= 1'b1;
            if (state_d == ST_UNDO_CLK) clk_en_q     <= 1'b0;
        end
    end

    assign periph_rst_o    = periph_rst_q;
    assign clk_en_o        = clk_en_q;
    assign req_idx_o       = idx_q;
    assign err_cause_o     = cause_q;
    assign busy_o          = (state_q != ST_IDLE);
    assign pwr_on_req_o    = (state_q == ST_PWR_REQ);
    assign clamp_rel_req_o = (state_q == ST_CLAMP);
    assign pwr_off_req_o   = (state_q == ST_UNDO_PWR);
    assign done_o          = (state_q == ST_DONE);
    assign err_o           = (state_q == ST_FAIL);

    p_rst_before_power_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on_req_o |-> periph_rst_o);
    p_clamp_needs_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_rel_req_o |-> (clk_en_o && periph_rst_o));
    p_power_on_then_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on_req_o |=> clk_en_o);
    p_off_without_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_req_o |-> (!clk_en_o && $fell(clk_en_o) == 1'b0));
    p_off_then_error_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_req_o |=> (err_o && err_cause_o == CAUSE_CLK_TIMEOUT));
    p_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !idx_ok) |=>
            (err_o && $stable(periph_rst_o) && $stable(clk_en_o)
             && $stable(req_idx_o) && err_cause_o == CAUSE_BAD_INDEX));
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(req_idx_o));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
    p_cause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_cause_o));
    p_done_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (clk_en_o && !periph_rst_o));
    p_one_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o, pwr_on_req_o, pwr_off_req_o, clamp_rel_req_o}));

endmodule

// File: tb/pup_sequencer_test.sv
module pup_sequencer_test;

    localparam int NP = 8;
    localparam int IW = 4;
    localparam int CW = 16;
    localparam int TO = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [IW-1:0] part_idx_i = '0;
    logic [CW-1:0] settle_cycles_i = '0;
    logic [NP-1:0] pwr_status_i = '0;
    logic          clk_ack_i = 1'b0;
    logic          periph_rst_o, clk_en_o, pwr_on_req_o, pwr_off_req_o;
    logic          clamp_rel_req_o, busy_o, done_o, err_o;
    logic [IW-1:0] req_idx_o;
    logic [1:0]    err_cause_o;

    pup_sequencer #(.NUM_PARTS(NP), .IDX_W(IW), .CNT_W(CW), .ACK_TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .part_idx_i(part_idx_i),
        .settle_cycles_i(settle_cycles_i), .pwr_status_i(pwr_status_i),
        .clk_ack_i(clk_ack_i), .periph_rst_o(periph_rst_o), .clk_en_o(clk_en_o),
        .pwr_on_req_o(pwr_on_req_o), .pwr_off_req_o(pwr_off_req_o),
        .clamp_rel_req_o(clamp_rel_req_o), .req_idx_o(req_idx_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .err_cause_o(err_cause_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Vector table: index, settle count, status mask, acknowledge present
    localparam int VN = 8;
    localparam int V_IDX [VN] = '{3, 7, 0, 5, 2, 9, 15, 6};
    localparam int V_N   [VN] = '{4, 1, 0, 3, 3, 2, 2, 10};
    localparam int V_ST  [VN] = '{0, 8'h7F, 0, 8'h20, 0, 0, 8'hFF, 8'hBF};
    localparam int V_ACK [VN] = '{1, 1, 1, 1, 0, 1, 1, 1};

    // Observations of one run
    int t_on, t_clk, t_clkfall, t_clamp, t_off, t_done, t_err;
    int on_cnt, clamp_cnt, idx_on, idx_clamp, idx_off, rst_at_on;
    int rst_end, clk_end, cause_end, pulse_after;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_seq(input int idx, input int n, input int st, input int ack,
                           input int busy_k, input int busy_idx);
        int prev_clk;
        t_on = -1; t_clk = -1; t_clkfall = -1; t_clamp = -1; t_off = -1;
        t_done = -1; t_err = -1; on_cnt = 0; clamp_cnt = 0;
        idx_on = -1; idx_clamp = -1; idx_off = -1; rst_at_on = -1;
        @(negedge clk);
        part_idx_i = IW'(idx);
        settle_cycles_i = CW'(n);
        pwr_status_i = NP'(st);
        clk_ack_i = (ack != 0);
        start_i = 1'b1;
        prev_clk = int'(clk_en_o);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (clk_en_o && prev_clk == 0 && t_clk < 0) t_clk = k;
            if (!clk_en_o && prev_clk == 1 && t_clkfall < 0) t_clkfall = k;
            prev_clk = int'(clk_en_o);
            if (pwr_on_req_o) begin
                on_cnt++;
                if (t_on < 0) begin t_on = k; idx_on = int'(req_idx_o); rst_at_on = int'(periph_rst_o); end
            end
            if (clamp_rel_req_o) begin
                clamp_cnt++;
                if (t_clamp < 0) begin t_clamp = k; idx_clamp = int'(req_idx_o); end
            end
            if (pwr_off_req_o && t_off < 0) begin t_off = k; idx_off = int'(req_idx_o); end
            if (done_o) t_done = k;
            if (err_o) t_err = k;
            if (done_o || err_o) break;
            if (k == busy_k) begin
                start_i = 1'b1;
                part_idx_i = IW'(busy_idx);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        @(negedge clk);
        pulse_after = int'(done_o) + int'(err_o);
        rst_end = int'(periph_rst_o);
        clk_end = int'(clk_en_o);
        cause_end = int'(err_cause_o);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        do_reset();
        chk("R8 reset held", int'(periph_rst_o), 1);
        chk("R8 clock off", int'(clk_en_o), 0);
        chk("R8 idle", int'(busy_o), 0);
        chk("R8 no pulses", int'(done_o | err_o | pwr_on_req_o | pwr_off_req_o | clamp_rel_req_o), 0);
        chk("R8 cause", int'(err_cause_o), 0);

        for (int v = 0; v < VN; v++) begin
            int idx, n, ne, st, ack, exp_cause;
            idx = V_IDX[v]; n = V_N[v]; st = V_ST[v]; ack = V_ACK[v];
            ne = (n == 0) ? 1 : n;
            if (idx >= NP)                 exp_cause = 1;
            else if (((st >> idx) & 1) != 0) exp_cause = 2;
            else if (ack == 0)             exp_cause = 3;
            else                           exp_cause = 0;
            do_reset();
            run_seq(idx, n, st, ack, -1, 0);
            chk("R7 cause code", cause_end, exp_cause);
            chk("R7 single-cycle result", pulse_after, 0);
            case (exp_cause)
                0: begin
                    chk("R1 reset held at power-on", rst_at_on, 1);
                    chk("R1 power-on time", t_on, 1);
                    chk("R1 power-on width", on_cnt, 1);
                    chk("R1 clock after power-on", t_clk, 2);
                    chk("R2 clamp delay", t_clamp - t_clk, ne + 1);
                    chk("R2 done delay", t_done - t_clamp, ne + 1);
                    chk("R1 clamp width", clamp_cnt, 1);
                    chk("R9 index at power-on", idx_on, idx);
                    chk("R9 index at clamp", idx_clamp, idx);
                    chk("R10 reset released", rst_end, 0);
                    chk("R10 clock left on", clk_end, 1);
                end
                1: begin
                    chk("R5 immediate error", t_err, 0);
                    chk("R5 no power-on", on_cnt, 0);
                    chk("R5 reset unchanged", rst_end, 1);
                    chk("R5 clock unchanged", clk_end, 0);
                end
                2: begin
                    chk("R3 error time", t_err, 1);
                    chk("R3 no power-on", on_cnt, 0);
                    chk("R3 clock off", clk_end, 0);
                    chk("R3 reset held", rst_end, 1);
                end
                default: begin
                    chk("R4 clock high length", t_clkfall - t_clk, TO);
                    chk("R4 power-off after clock", t_off - t_clkfall, 1);
                    chk("R4 error after power-off", t_err - t_off, 1);
                    chk("R9 index at power-off", idx_off, idx);
                    chk("R4 reset held", rst_end, 1);
                    chk("R4 clock off", clk_end, 0);
                end
            endcase
        end

        // R6: a second start while busy is ignored
        do_reset();
        run_seq(1, 5, 0, 1, 3, 12);
        chk("R6 no error", t_err, -1);
        chk("R6 done timing", t_done, 4 + 2 * 5);
        chk("R6 index kept", idx_clamp, 1);

        // R5: rejection after a success leaves the outputs alone
        run_seq(10, 2, 0, 1, -1, 0);
        chk("R5 immediate error after success", t_err, 0);
        chk("R5 reset stays released", rst_end, 0);
        chk("R5 clock stays on", clk_end, 1);
        chk("R5 index unchanged", int'(req_idx_o), 1);

        // R7: cause held in idle, then cleared by an accepted start
        repeat (5) @(negedge clk);
        chk("R7 cause held", int'(err_cause_o), 1);
        @(negedge clk);
        part_idx_i = IW'(4);
        pwr_status_i = '0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R7 cause cleared on start", int'(err_cause_o), 0);
        repeat (30) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule